// File: doc/BRIEF.md
# Shared Byte FIFO with Water-Level Alerts

This block is a 64-deep, byte-wide buffer placed between a host register port and an internal data engine. Either side may push bytes into it or pop bytes out of it. It reports how many bytes it holds, and it raises two alert flags against a programmable 6-bit threshold. The low alert tracks the number of stored bytes and the high alert tracks the remaining free space. A sticky overflow error records any attempt to write into a full buffer.

Host pushes and host pops are never back-pressured. A host push into a full buffer is consumed and dropped, and a host pop on an empty buffer returns zero. The engine side uses a valid/ready handshake. An engine beat transfers only in a cycle where both valid and ready are high. Engine push ready is low in any cycle where the host also pushes, and engine pop ready is low in any cycle where the host also pops. The engine keeps its beat presented until ready returns. A flush strobe empties the buffer and clears the overflow error in the same clock edge.

Top module: `shared_byte_fifo`

## Requirements
- R1: After reset the fill count is 0, the overflow error is 0, the low alert is 1 and the high alert is 0.
- R2: Each accepted push raises the fill count by one and each pop on a non-empty buffer lowers it by one. Bytes leave in the order they entered. The count ranges from 0 to 64 in a 7-bit field.
- R3: A push from either side while the count is 64 (judged before that cycle's pop) is discarded and sets the overflow error. The error stays set until a flush.
- R4: A flush empties the buffer and clears the overflow error at the next edge. Pushes and pops presented in the flush cycle have no effect.
- R5: The high alert is 1 exactly when (64 − count) ≤ water_level. With a level of 4, a count of 60 gives 1 and a count of 59 gives 0.
- R6: The low alert is 1 exactly when count ≤ water_level. With a level of 4, a count of 4 gives 1 and a count of 5 gives 0.
- R7: When both sides push in the same cycle, the host byte is stored and engine push ready is 0. An engine byte presented again in the next cycle, with no host push, is stored after the host byte.
- R8: When both sides pop in the same cycle, only one byte is removed and engine pop ready is 0. Both pop data outputs always show the head byte.
- R9: A push and a pop in the same cycle on a buffer holding between 1 and 63 bytes leave the count unchanged.
- R10: A pop on an empty buffer returns 0x00 on the pop data outputs and leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the buffer and clear the overflow error |
| water_level | input | 6 | Alert threshold |
| host_push_valid | input | 1 | Host write strobe |
| host_push_data | input | 8 | Host write byte |
| eng_push_valid | input | 1 | Engine push valid |
| eng_push_data | input | 8 | Engine push byte |
| eng_push_ready | output | 1 | Engine push accepted this cycle |
| host_pop_valid | input | 1 | Host read strobe |
| host_pop_data | output | 8 | Head byte (0x00 when empty) |
| eng_pop_valid | input | 1 | Engine pop valid |
| eng_pop_ready | output | 1 | Engine pop accepted this cycle |
| eng_pop_data | output | 8 | Head byte (0x00 when empty) |
| fill_count | output | 7 | Stored byte count |
| hi_alert | output | 1 | Free space at or below threshold |
| lo_alert | output | 1 | Fill at or below threshold |
| overflow_err | output | 1 | Sticky write-while-full error |

## Verification
The assertions assume that every strobe, including flush, is a defined 0 or 1 outside reset. They also assume water_level is a defined value. The alert check that rules out both flags together claims only thresholds below half the depth. The stimulus drives every input on the falling edge with known values, and it keeps each threshold fixed for at least one full cycle. The stimulus includes both legal and out-of-rule writes, such as pushes into a full buffer and pops on an empty one. Those writes are part of the specified behaviour, so no input assumption excludes them.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HOST = 2'd1,
    SRC_ENG  = 2'd2
  } src_e;
endpackage

// File: rtl/sbf_arbiter.sv
module sbf_arbiter
  import sbf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              host_push_valid,
  input  logic [DATA_W-1:0] host_push_data,
  input  logic              eng_push_valid,
  input  logic [DATA_W-1:0] eng_push_data,
  input  logic              host_pop_valid,
  input  logic              eng_pop_valid,
  output logic              eng_push_ready,
  output logic              eng_pop_ready,
  output logic              push_req,
  output logic [DATA_W-1:0] push_data,
  output logic              pop_req
);
  src_e push_src, pop_src;

  always_comb begin
    if (host_push_valid)     push_src = SRC_HOST;
    else if (eng_push_valid) push_src = SRC_ENG;
    else                     push_src = SRC_NONE;

    if (host_pop_valid)      pop_src = SRC_HOST;
    else if (eng_pop_valid)  pop_src = SRC_ENG;
    else                     pop_src = SRC_NONE;
  end

  always_comb begin
    unique case (push_src)
      SRC_HOST: push_data = host_push_data;
      SRC_ENG:  push_data = eng_push_data;
      default:  push_data = '0;
    endcase
  end

  assign push_req       = (push_src != SRC_NONE);
  assign pop_req        = (pop_src != SRC_NONE);
  assign eng_push_ready = (push_src != SRC_HOST);
  assign eng_pop_ready  = (pop_src != SRC_HOST);
endmodule

// File: rtl/sbf_store.sv
module sbf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head_data,
  output logic [CW-1:0]     count,
  output logic              overflow
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              full, empty, push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push_req & ~full & ~flush;
  assign pop_ok  = pop_req & ~empty & ~flush;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else if (flush) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push_ok) wptr <= nxt(wptr);
      if (pop_ok)  rptr <= nxt(rptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
      if (push_req && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  assign head_data = empty ? '0 : mem[rptr];

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_ovfl_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !flush |=> overflow);
  assert_full_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) && push_req && !flush |=> overflow);
  assert_flush_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && !overflow);
  assert_balanced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && pop_req && !flush && (count != '0) && (count != CW'(DEPTH))
    |=> count == $past(count));
  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) && !push_req && !flush |=> count == '0);
endmodule

// File: rtl/sbf_level.sv
module sbf_level #(
  parameter int DEPTH   = 64,
  parameter int LEVEL_W = 6,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int XW     = ((CW > LEVEL_W) ? CW : LEVEL_W) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW-1:0]      count,
  input  logic [LEVEL_W-1:0] water_level,
  output logic               hi_alert,
  output logic               lo_alert
);
  logic [XW-1:0] fill_x, free_x, lvl_x;

  assign fill_x   = XW'(count);
  assign free_x   = XW'(DEPTH) - fill_x;
  assign lvl_x    = XW'(water_level);
  assign hi_alert = (free_x <= lvl_x);
  assign lo_alert = (fill_x <= lvl_x);

  assert_alert_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_x < XW'(DEPTH / 2)) |-> !(hi_alert && lo_alert));
  assert_empty_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> lo_alert);
endmodule

// File: rtl/shared_byte_fifo.sv
module shared_byte_fifo #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 64,
  parameter int LEVEL_W = 6,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [LEVEL_W-1:0] water_level,
  input  logic               host_push_valid,
  input  logic [DATA_W-1:0]  host_push_data,
  input  logic               eng_push_valid,
  input  logic [DATA_W-1:0]  eng_push_data,
  output logic               eng_push_ready,
  input  logic               host_pop_valid,
  output logic [DATA_W-1:0]  host_pop_data,
  input  logic               eng_pop_valid,
  output logic               eng_pop_ready,
  output logic [DATA_W-1:0]  eng_pop_data,
  output logic [CW-1:0]      fill_count,
  output logic               hi_alert,
  output logic               lo_alert,
  output logic               overflow_err
);
  logic              push_req, pop_req;
  logic [DATA_W-1:0] push_data, head_data;

  sbf_arbiter #(.DATA_W(DATA_W)) u_arb (
    .host_push_valid(host_push_valid),
    .host_push_data (host_push_data),
    .eng_push_valid (eng_push_valid),
    .eng_push_data  (eng_push_data),
    .host_pop_valid (host_pop_valid),
    .eng_pop_valid  (eng_pop_valid),
    .eng_push_ready (eng_push_ready),
    .eng_pop_ready  (eng_pop_ready),
    .push_req       (push_req),
    .push_data      (push_data),
    .pop_req        (pop_req)
  );

  sbf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push_req (push_req),
    .push_data(push_data),
    .pop_req  (pop_req),
    .head_data(head_data),
    .count    (fill_count),
    .overflow (overflow_err)
  );

  sbf_level #(.DEPTH(DEPTH), .LEVEL_W(LEVEL_W)) u_level (
    .clk        (clk),
    .rst_n      (rst_n),
    .count      (fill_count),
    .water_level(water_level),
    .hi_alert   (hi_alert),
    .lo_alert   (lo_alert)
  );

  assign host_pop_data = head_data;
  assign eng_pop_data  = head_data;

  assert_eng_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_push_valid && eng_push_valid && !flush && (fill_count < CW'(DEPTH))
    |=> fill_count != '0);
endmodule

// File: tb/shared_byte_fifo_tb.sv
`timescale 1ns/1ps
module shared_byte_fifo_tb;
  logic       clk = 1'b0;
  logic       rst_n, flush;
  logic [5:0] wl;
  logic       hpv, epv, hrv, erv;
  logic [7:0] hpd, epd;
  logic       eng_push_ready, eng_pop_ready, hi_alert, lo_alert, overflow_err;
  logic [7:0] host_pop_data, eng_pop_data;
  logic [6:0] fill_count;

  int n_run = 0, n_fail = 0;
  logic [7:0] q[$];
  bit m_ovf = 0;

  always #2.5 clk = ~clk;

  shared_byte_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .water_level(wl),
    .host_push_valid(hpv), .host_push_data(hpd),
    .eng_push_valid(epv), .eng_push_data(epd), .eng_push_ready(eng_push_ready),
    .host_pop_valid(hrv), .host_pop_data(host_pop_data),
    .eng_pop_valid(erv), .eng_pop_ready(eng_pop_ready), .eng_pop_data(eng_pop_data),
    .fill_count(fill_count), .hi_alert(hi_alert), .lo_alert(lo_alert),
    .overflow_err(overflow_err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    int n = q.size();
    chk("R2 fill count", fill_count, n);
    chk("R5 high alert", hi_alert, ((64 - n) <= int'(wl)) ? 1 : 0);
    chk("R6 low alert", lo_alert, (n <= int'(wl)) ? 1 : 0);
    chk("R3 overflow", overflow_err, m_ovf);
    chk("R7 engine push ready", eng_push_ready, !hpv);
    chk("R8 engine pop ready", eng_pop_ready, !hrv);
    chk("R10 host pop data", host_pop_data, n > 0 ? q[0] : 8'h00);
    chk("R8 engine pop data", eng_pop_data, n > 0 ? q[0] : 8'h00);
  endtask

  task automatic cyc(bit a_hpv, logic [7:0] a_hpd, bit a_epv, logic [7:0] a_epd,
                     bit a_hrv, bit a_erv, bit a_fl);
    int pre;
    hpv = a_hpv; hpd = a_hpd; epv = a_epv; epd = a_epd;
    hrv = a_hrv; erv = a_erv; flush = a_fl;
    #1;
    compare();
    @(posedge clk);
    if (a_fl) begin
      q.delete();
      m_ovf = 0;
    end else begin
      pre = q.size();
      if ((a_hrv || a_erv) && pre > 0) void'(q.pop_front());
      if (a_hpv) begin
        if (pre == 64) m_ovf = 1; else q.push_back(a_hpd);
      end else if (a_epv) begin
        if (pre == 64) m_ovf = 1; else q.push_back(a_epd);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n0;
    rst_n = 0; flush = 0; wl = 6'd4;
    hpv = 0; epv = 0; hrv = 0; erv = 0; hpd = 0; epd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset count", fill_count, 0);
    chk("R1 reset overflow", overflow_err, 0);
    chk("R1 reset low alert", lo_alert, 1);
    chk("R1 reset high alert", hi_alert, 0);
    @(negedge clk);

    // host fills past full: alerts cross at 4/5 and 59/60, R3 on the 65th write
    for (int i = 0; i < 66; i++) cyc(1, 8'(i + 1), 0, 0, 0, 0, 0);
    chk("R3 error after host overfill", overflow_err, 1);
    // flush wins over a same-cycle push (R4)
    cyc(1, 8'hEE, 0, 0, 1, 0, 1);
    chk("R4 flush empties", fill_count, 0);
    chk("R4 flush clears error", overflow_err, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);

    // both sides push: host first, engine retries next cycle (R7)
    cyc(1, 8'hA1, 1, 8'hB2, 0, 0, 0);
    cyc(0, 0, 1, 8'hB2, 0, 0, 0);
    chk("R7 both stored", fill_count, 2);
    chk("R7 host byte first", host_pop_data, 8'hA1);
    // push and pop together keeps count (R9)
    n0 = q.size();
    cyc(1, 8'hC3, 0, 0, 1, 0, 0);
    chk("R9 count unchanged", fill_count, n0);
    // both sides pop: one byte leaves (R8)
    cyc(0, 0, 0, 0, 1, 1, 0);
    chk("R8 single removal", fill_count, n0 - 1);
    // drain and pop empty (R10)
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, i % 2, 1, 0);
    chk("R10 empty count", fill_count, 0);
    chk("R10 empty data", eng_pop_data, 8'h00);

    // engine fills and overflows (R3 from engine side)
    wl = 6'd10;
    for (int i = 0; i < 65; i++) cyc(0, 0, 1, 8'(8'h40 + i), 0, 0, 0);
    chk("R3 error after engine overfill", overflow_err, 1);
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R3 error sticky after pop", overflow_err, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) wl = 6'($urandom_range(0, 63));
      cyc($urandom_range(0, 2) == 0, 8'($urandom), $urandom_range(0, 1) == 1,
          8'($urandom), $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0,
          $urandom_range(0, 80) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule